// File: doc/BRIEF.md
# Edge-Interrupt Pending Latch Controller

This block keeps one pending flag per interrupt source and turns it into a request line that a later priority stage can consume. Each source can run in edge mode, where a rising edge on its synchronized line sets a sticky pending flag, or in level mode, where the request simply follows the synchronized line and nothing is latched. A per-source mask gates the request without ever dropping the pending flag. A service-acknowledge pulse clears the flag of the interrupt whose handler is being entered.

Software reaches the pending flags through a write-only command port that carries a force field and a clear field, one bit per source. A command is captured on the write edge and applied on the following edge, so it acts one cycle later than a direct write would. Sources marked as internal always behave as edge sources whatever their mode input says. Sources marked as host-port sources cannot be forced or cleared by software at all.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While reset is asserted and right after it, pending_o and req_o are all zero.
- R2: In edge mode a rising edge on irq_line_i sets that source's pending bit, which becomes visible after the third rising clock edge following the line change (two synchronizer stages plus the pending register) and stays set after the line falls.
- R3: In level mode nothing is latched: pending_o and req_o follow the line, delayed by the two synchronizer edges, and drop when it drops.
- R4: A mask bit of 1 forces req_o low for that source while its pending bit is kept; clearing the mask bit brings the request back in the same cycle.
- R5: A force bit written with cfg_wr_i sets the pending bit at the second rising clock edge after the write cycle, not at the first.
- R6: A force aimed at an external source in level mode is ignored.
- R7: A clear bit written with cfg_wr_i removes a pending bit at the second rising clock edge after the write cycle.
- R8: When force and clear are written together for one source, clear wins and the pending bit ends at zero.
- R9: A svc_ack_i pulse clears the pending bit at the next edge; a force or a new edge applied at that same edge wins and the bit stays set.
- R10: Internal sources (default bits 6 and 5) latch edges and accept force even with trig_edge_i low.
- R11: Host-port sources (default bit 7) ignore both force and clear; only their line edge sets them and svc_ack_i clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_line_i | input | NUM_SRC | Raw interrupt lines, asynchronous |
| trig_edge_i | input | NUM_SRC | 1 = edge mode, 0 = level mode, per source |
| irq_mask_i | input | NUM_SRC | 1 = request masked |
| cfg_wr_i | input | 1 | Write strobe of the force/clear command |
| cfg_force_i | input | NUM_SRC | Force field, one bit per source |
| cfg_clear_i | input | NUM_SRC | Clear field, one bit per source |
| svc_ack_i | input | NUM_SRC | Service-routine entry pulse, one bit per source |
| pending_o | output | NUM_SRC | Pending flags (level sources show the synchronized line) |
| req_o | output | NUM_SRC | Pending flags gated by the mask |

## Verification
The two collisions that matter are a software clear meeting a software force on the same source, and a service acknowledge meeting a force on the same edge. The first is provoked by one write carrying both bits, on a source that is already pending and on one that is idle, and the pending bit must end at zero in both. The second is provoked by raising svc_ack_i in exactly the cycle in which a delayed force lands on an already pending source, and the bit must stay set; a lone acknowledge right after must drop it.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  typedef struct packed {
    logic frc;
    logic clr;
  } swcmd_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_swreg.sv
module irq_swreg #(
  parameter int           W        = 8,
  parameter logic [W-1:0] HOST_SRC = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] force_i,
  input  logic [W-1:0] clear_i,
  output logic [W-1:0] frc_o,
  output logic [W-1:0] clr_o
);

  logic [W-1:0] frc_q, frc_d;
  logic [W-1:0] clr_q, clr_d;
  logic         upd_en;

  always_comb begin
    upd_en = wr_i | (|frc_q) | (|clr_q);
    if (wr_i) begin
      frc_d = force_i & ~clear_i & ~HOST_SRC;
      clr_d = clear_i & ~HOST_SRC;
    end else begin
      frc_d = '0;
      clr_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frc_q <= '0;
      clr_q <= '0;
    end else if (upd_en) begin
      frc_q <= frc_d;
      clr_q <= clr_d;
    end
  end

  assign frc_o = frc_q;
  assign clr_o = clr_q;

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_q & clr_q) == '0); // R8

  AST_HOST_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((frc_q | clr_q) & HOST_SRC) == '0); // R11

endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell
  import irq_pkg::*;
#(
  parameter bit IS_HOST     = 1'b0,
  parameter bit IS_INTERNAL = 1'b0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_i,
  input  trig_e  trig_i,
  input  logic   mask_i,
  input  swcmd_t cmd_i,
  input  logic   ack_i,
  output logic   pending_o,
  output logic   req_o
);

  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic pend_en;
  logic edge_on;
  logic rise;
  logic frc_ok;
  logic clr_ok;

  always_comb begin
    edge_on = IS_INTERNAL ? 1'b1 : (trig_i == TRIG_EDGE);
    rise    = line_i & ~prev_q;
    frc_ok  = cmd_i.frc & edge_on;
    clr_ok  = cmd_i.clr & edge_on;
    prev_d  = line_i;
    if (!edge_on) begin
      pend_d = 1'b0;
    end else if (clr_ok) begin
      pend_d = 1'b0;
    end else if (rise || frc_ok) begin
      pend_d = 1'b1;
    end else if (ack_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
    pend_en = (pend_d != pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign pending_o = edge_on ? pend_q : line_i;
  assign req_o     = pending_o & ~mask_i;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ok |=> !pend_q); // R8

  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !rise && !frc_ok) |=> !pend_q); // R9

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_on |=> !pend_q); // R3

  AST_MASK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && pend_q && edge_on && !ack_i && !clr_ok) |=> pend_q); // R4

  generate
    if (IS_HOST) begin : g_host
      AST_HOST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_on && !rise && !ack_i) |=> $stable(pend_q)); // R11
    end
  endgenerate

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
#(
  parameter int                 NUM_SRC      = 8,
  parameter int                 SYNC_STAGES  = 2,
  parameter logic [NUM_SRC-1:0] HOST_SRC     = 8'b1000_0000,
  parameter logic [NUM_SRC-1:0] INTERNAL_SRC = 8'b0110_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_line_i,
  input  logic [NUM_SRC-1:0] trig_edge_i,
  input  logic [NUM_SRC-1:0] irq_mask_i,
  input  logic               cfg_wr_i,
  input  logic [NUM_SRC-1:0] cfg_force_i,
  input  logic [NUM_SRC-1:0] cfg_clear_i,
  input  logic [NUM_SRC-1:0] svc_ack_i,
  output logic [NUM_SRC-1:0] pending_o,
  output logic [NUM_SRC-1:0] req_o
);

  logic               rst_n;
  logic [NUM_SRC-1:0] line_sync;
  logic [NUM_SRC-1:0] frc_q;
  logic [NUM_SRC-1:0] clr_q;

  irq_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  irq_sync #(
    .W      (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (irq_line_i),
    .sync_o  (line_sync)
  );

  irq_swreg #(
    .W        (NUM_SRC),
    .HOST_SRC (HOST_SRC)
  ) u_swreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_i    (cfg_wr_i),
    .force_i (cfg_force_i),
    .clear_i (cfg_clear_i),
    .frc_o   (frc_q),
    .clr_o   (clr_q)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      swcmd_t cmd;
      trig_e  trig;
      assign cmd.frc = frc_q[i];
      assign cmd.clr = clr_q[i];
      assign trig    = trig_edge_i[i] ? TRIG_EDGE : TRIG_LEVEL;

      irq_pend_cell #(
        .IS_HOST     (HOST_SRC[i]),
        .IS_INTERNAL (INTERNAL_SRC[i])
      ) u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_n),
        .line_i    (line_sync[i]),
        .trig_i    (trig),
        .mask_i    (irq_mask_i[i]),
        .cmd_i     (cmd),
        .ack_i     (svc_ack_i[i]),
        .pending_o (pending_o[i]),
        .req_o     (req_o[i])
      );
    end
  endgenerate

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n |-> (req_o & ~irq_line_i & ~line_sync) == '0); // R1

  AST_FORCE_DELAYED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_wr_i && (frc_q == '0) && (clr_q == '0) && (svc_ack_i == '0)
     && (cfg_force_i != '0)) |=> (frc_q != '0) || (cfg_force_i & ~cfg_clear_i & ~HOST_SRC) == '0 || $past(cfg_force_i & ~cfg_clear_i & ~HOST_SRC) == '0); // R5

endmodule

// File: tb/sim_irq_pend_ctrl.sv
`timescale 1ns/1ps
module sim_irq_pend_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] line, mode, mask, frc, clr, ack;
  logic       wr;
  logic [7:0] pend, req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_pend_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_line_i  (line),
    .trig_edge_i (mode),
    .irq_mask_i  (mask),
    .cfg_wr_i    (wr),
    .cfg_force_i (frc),
    .cfg_clear_i (clr),
    .svc_ack_i   (ack),
    .pending_o   (pend),
    .req_o       (req)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [7:0] f, input logic [7:0] c);
    wr = 1'b1; frc = f; clr = c;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; frc = '0; clr = '0;
  endtask

  task automatic ack_pulse(input logic [7:0] a);
    ack = a;
    tick(1);
    ack = '0;
  endtask

  task automatic t_reset;
    chk("R1 pending after reset", |pend, 1'b0);
    chk("R1 req after reset", |req, 1'b0);
  endtask

  task automatic t_edge;
    line[0] = 1'b1;
    tick(2);
    chk("R2 not yet at edge 2", pend[0], 1'b0);
    tick(1);
    chk("R2 set at edge 3", pend[0], 1'b1);
    line[0] = 1'b0;
    tick(3);
    chk("R2 sticky after line low", pend[0], 1'b1);
    ack_pulse(8'h01);
    chk("R9 ack clears", pend[0], 1'b0);
  endtask

  task automatic t_level;
    line[3] = 1'b1;
    tick(1);
    chk("R3 level after 1 edge", pend[3], 1'b0);
    tick(1);
    chk("R3 level pending follows", pend[3], 1'b1);
    chk("R3 level req follows", req[3], 1'b1);
    line[3] = 1'b0;
    tick(2);
    chk("R3 level drops", pend[3], 1'b0);
    sw_write(8'h08, 8'h00);
    tick(2);
    chk("R6 force on level ignored", pend[3], 1'b0);
  endtask

  task automatic t_force_clear;
    sw_write(8'h02, 8'h00);
    chk("R5 force not at first edge", pend[1], 1'b0);
    tick(1);
    chk("R5 force at second edge", pend[1], 1'b1);
    sw_write(8'h00, 8'h02);
    chk("R7 clear not at first edge", pend[1], 1'b1);
    tick(1);
    chk("R7 clear at second edge", pend[1], 1'b0);
    sw_write(8'h02, 8'h00);
    tick(1);
    sw_write(8'h02, 8'h02);
    tick(1);
    chk("R8 clear wins on pending source", pend[1], 1'b0);
    sw_write(8'h02, 8'h02);
    tick(2);
    chk("R8 clear wins on idle source", pend[1], 1'b0);
  endtask

  task automatic t_ack_race;
    sw_write(8'h04, 8'h00);
    tick(1);
    chk("R9 setup pending", pend[2], 1'b1);
    sw_write(8'h04, 8'h00);
    ack_pulse(8'h04);
    chk("R9 force beats ack", pend[2], 1'b1);
    ack_pulse(8'h04);
    chk("R9 lone ack clears", pend[2], 1'b0);
  endtask

  task automatic t_mask;
    mask[4] = 1'b1;
    line[4] = 1'b1;
    tick(3);
    chk("R4 pending kept while masked", pend[4], 1'b1);
    chk("R4 req gated", req[4], 1'b0);
    mask[4] = 1'b0;
    #1;
    chk("R4 req returns on unmask", req[4], 1'b1);
    line[4] = 1'b0;
    tick(3);
    ack_pulse(8'h10);
    chk("R4 cleanup", pend[4], 1'b0);
  endtask

  task automatic t_internal;
    line[5] = 1'b1;
    tick(3);
    chk("R10 internal latches edge", pend[5], 1'b1);
    line[5] = 1'b0;
    tick(3);
    chk("R10 internal sticky", pend[5], 1'b1);
    sw_write(8'h40, 8'h00);
    tick(1);
    chk("R10 internal force", pend[6], 1'b1);
    ack_pulse(8'h60);
    chk("R10 internal ack", pend[5] | pend[6], 1'b0);
  endtask

  task automatic t_host;
    sw_write(8'h80, 8'h00);
    tick(2);
    chk("R11 host force ignored", pend[7], 1'b0);
    line[7] = 1'b1;
    tick(3);
    chk("R11 host edge sets", pend[7], 1'b1);
    sw_write(8'h00, 8'h80);
    tick(2);
    chk("R11 host clear ignored", pend[7], 1'b1);
    ack_pulse(8'h80);
    chk("R11 host ack clears", pend[7], 1'b0);
    line[7] = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line = '0; mask = '0; frc = '0; clr = '0; ack = '0; wr = 1'b0;
    mode = 8'b1001_0111;
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", |pend, 1'b0);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_edge();
    t_level();
    t_force_clear();
    t_ack_race();
    t_mask();
    t_internal();
    t_host();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule